// File: doc/BRIEF.md
# GPIO Level Interrupt Router

This block turns up to fourteen already-synchronized GPIO pin levels into two interrupt lines. Each pin has a polarity bit that picks whether a high or a low level counts as active. The active pin bits sit in a GPIO field that starts at bit 18 of a set of 32-bit enable, mask and cause words. Bits 0 to 17 of the synchronous words carry a vector of other level sources. The asynchronous words also have a MAC interrupt bit at bit 0.

The synchronous path latches each active, enabled source into a sticky cause register. Software clears a cause bit by writing a one to that bit at the cause address. The synchronous line is raised while any latched cause bit is also masked in. The asynchronous path has no storage. It ORs the live active bits that are both enabled and masked, and it is held low while the sleep input is high.

Software runs the block through a small register bus. A write takes effect at the clock edge. A read is combinational from the address.

To retire a pin, software:
1. clears the pin's bit in the four enable and mask words;
2. then writes a one to the pin's cause bit.

Top module: `gpio_irq_router`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero, `sync_irq` is low and `async_irq` is low.
- R2: Polarity register bit p (address 0, bits NUM_PINS-1:0) selects the active level of pin p. A value of 0 makes the pin active while it is high, and a value of 1 makes it active while it is low. Unused polarity bits read zero.
- R3: The register addresses are:
  - 0: polarity
  - 1: sync enable
  - 2: sync mask
  - 3: sync cause
  - 4: async enable
  - 5: async mask
  
  Pin p maps to bit 18+p of the enable, mask and cause words. The enable and mask words read back the last value written. Addresses 6 and 7 read zero.
- R4: A sync cause bit is set at a clock edge where its source is active and its sync enable bit is 1. The bit stays set after the source goes inactive.
- R5: Writing to address 3 clears each cause bit whose write-data bit is 1 and leaves the others unchanged. If a clear and a set of the same bit happen in the same cycle, the set wins.
- R6: `sync_irq` is high exactly when some cause bit and the matching sync mask bit are both 1.
- R7: `async_irq` is combinational and is high when either of these holds:
  - an active pin's bit is 1 in both async enable and async mask;
  - `mac_irq` is high and bit 0 is 1 in both async enable and async mask.
- R8: While `sleep` is high, `async_irq` is low. `sleep` has no effect on the sync path.
- R9: Bit i of `other_sync_src` (i < 18) sets cause bit i under sync enable bit i, following the same rules as R4 and R5.
- R10: After the pin's enable and mask bits are cleared and its cause bit is cleared, both lines stay low even while the pin remains active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_level | input | NUM_PINS | Synchronized GPIO pin levels |
| mac_irq | input | 1 | MAC interrupt level for the async path |
| other_sync_src | input | 18 | Non-GPIO synchronous interrupt source levels |
| sleep | input | 1 | Sleep indication; holds the async line low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| sync_irq | output | 1 | Synchronous interrupt line |
| async_irq | output | 1 | Asynchronous interrupt line |

## Verification
Every pin is swept through all four combinations of polarity and level, with all other pins held inactive. This separates a correct XOR from a missing inversion and from cross-talk between bit positions. Each pin then goes through a latch, release and clear pass, which shows stickiness apart from a live level and shows that the cause bit lands at bit 18+p. Directed patterns then cover:
- a clear in the same cycle as a set;
- a partial clear;
- a mask that hides a latched cause;
- sleep versus the MAC bit;
- the non-GPIO source vector;
- the full disable sequence.

// File: rtl/gpio_irq_pkg.sv
// Shared constants for the GPIO interrupt router.
// Assumes a 32-bit register word and a GPIO field starting at bit 18.
package gpio_irq_pkg;
    localparam int WORD_W   = 32;
    localparam int GPIO_LSB = 18;
    localparam int ADDR_W   = 3;
    localparam int MAC_BIT  = 0;

    localparam logic [ADDR_W-1:0] REG_POL    = 3'd0;
    localparam logic [ADDR_W-1:0] REG_SEN    = 3'd1;
    localparam logic [ADDR_W-1:0] REG_SMSK   = 3'd2;
    localparam logic [ADDR_W-1:0] REG_SCAUSE = 3'd3;
    localparam logic [ADDR_W-1:0] REG_AEN    = 3'd4;
    localparam logic [ADDR_W-1:0] REG_AMSK   = 3'd5;
endpackage

// File: rtl/gpio_irq_regs.sv
// Register file: polarity, sync/async enable and mask words, the cause
// clear strobe vector and the combinational read mux.
// Assumes the cause register itself lives outside and is fed back for reads.
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    input  logic [WORD_W-1:0]   cause_q,
    output logic [NUM_PINS-1:0] pol_q,
    output logic [WORD_W-1:0]   sen_q,
    output logic [WORD_W-1:0]   smsk_q,
    output logic [WORD_W-1:0]   aen_q,
    output logic [WORD_W-1:0]   amsk_q,
    output logic [WORD_W-1:0]   cause_clr,
    output logic [WORD_W-1:0]   bus_rdata
);

    // Store writes to the configuration words; all clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q  <= '0;
            sen_q  <= '0;
            smsk_q <= '0;
            aen_q  <= '0;
            amsk_q <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                REG_POL:  pol_q  <= bus_wdata[NUM_PINS-1:0];
                REG_SEN:  sen_q  <= bus_wdata;
                REG_SMSK: smsk_q <= bus_wdata;
                REG_AEN:  aen_q  <= bus_wdata;
                REG_AMSK: amsk_q <= bus_wdata;
                default: ;
            endcase
        end
    end

    // Decode a write at the cause address into a one-cycle clear vector.
    always_comb begin
        cause_clr = (bus_wr && bus_addr == REG_SCAUSE) ? bus_wdata : '0;
    end

    // Select the read word for the current address.
    always_comb begin
        case (bus_addr)
            REG_POL:    bus_rdata = WORD_W'(pol_q);
            REG_SEN:    bus_rdata = sen_q;
            REG_SMSK:   bus_rdata = smsk_q;
            REG_SCAUSE: bus_rdata = cause_q;
            REG_AEN:    bus_rdata = aen_q;
            REG_AMSK:   bus_rdata = amsk_q;
            default:    bus_rdata = '0;
        endcase
    end

    AST_SEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bus_wr) && $past(bus_addr) == REG_SEN) |-> (sen_q == $past(bus_wdata))); // R3

    AST_AMSK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bus_wr) && $past(bus_addr) == REG_AMSK) |-> (amsk_q == $past(bus_wdata))); // R3

endmodule

// File: rtl/gpio_irq_cause.sv
// Sticky synchronous cause register with write-one-to-clear.
// Assumes set_vec is already gated by the sync enable word; set beats clear.
module gpio_irq_cause
    import gpio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] set_vec,
    input  logic [WORD_W-1:0] clr_vec,
    output logic [WORD_W-1:0] cause_q
);

    // Hold pending bits, drop cleared ones, then add new sets on top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
        end else begin
            cause_q <= (cause_q & ~clr_vec) | set_vec;
        end
    end

    AST_CAUSE_ONLY_FROM_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ((cause_q & ~$past(cause_q) & ~$past(set_vec)) == '0)); // R4

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        ((cause_q & $past(clr_vec) & ~$past(set_vec)) == '0)); // R5

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ((~cause_q & $past(set_vec)) == '0)); // R5

endmodule

// File: rtl/gpio_irq_combine.sv
// Output combiner: sync line from masked causes, async line from live
// active sources under enable and mask, blanked during sleep.
// Assumes async_src already places pins in the GPIO field and MAC at bit 0.
module gpio_irq_combine
    import gpio_irq_pkg::*;
(
    input  logic [WORD_W-1:0] cause_q,
    input  logic [WORD_W-1:0] smsk_q,
    input  logic [WORD_W-1:0] async_src,
    input  logic [WORD_W-1:0] aen_q,
    input  logic [WORD_W-1:0] amsk_q,
    input  logic              sleep,
    output logic              sync_irq,
    output logic              async_irq
);

    logic [WORD_W-1:0] sync_hit;
    logic [WORD_W-1:0] async_hit;

    // Reduce masked pending causes to the sync line.
    always_comb begin
        sync_hit = cause_q & smsk_q;
        sync_irq = |sync_hit;
    end

    // Reduce live enabled and masked sources to the async line unless asleep.
    always_comb begin
        async_hit = async_src & aen_q & amsk_q;
        async_irq = (|async_hit) && !sleep;
    end

    always_comb begin
        AST_SLEEP_QUIET: assert (!(sleep && async_irq)); // R8
        AST_SYNC_NEEDS_CAUSE: assert (!sync_irq || (cause_q != '0)); // R6
    end

endmodule

// File: rtl/gpio_irq_router.sv
// Top: per-pin polarity, source assembly, register file, cause latch and
// output combiner. Pin levels are assumed already synchronized to clk.
module gpio_irq_router
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 14
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   pin_level,
    input  logic                  mac_irq,
    input  logic [GPIO_LSB-1:0]   other_sync_src,
    input  logic                  sleep,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [WORD_W-1:0]     bus_wdata,
    output logic [WORD_W-1:0]     bus_rdata,
    output logic                  sync_irq,
    output logic                  async_irq
);

    localparam int GPIO_MSB = GPIO_LSB + NUM_PINS - 1;

    logic [NUM_PINS-1:0] pol_q;
    logic [NUM_PINS-1:0] pin_active;
    logic [WORD_W-1:0]   sen_q, smsk_q, aen_q, amsk_q;
    logic [WORD_W-1:0]   cause_q, cause_clr;
    logic [WORD_W-1:0]   gpio_word, sync_src, async_src, cause_set;

    initial begin
        if (GPIO_MSB >= WORD_W) $display("gpio_irq_router: NUM_PINS too large");
    end

    // One polarity XOR per pin.
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        // Active when the level differs from the polarity bit.
        always_comb begin
            pin_active[p] = pin_level[p] ^ pol_q[p];
        end
    end

    // Place pins into the GPIO field and build both source words.
    always_comb begin
        gpio_word = WORD_W'(pin_active) << GPIO_LSB;
        sync_src  = gpio_word | WORD_W'(other_sync_src);
        async_src = gpio_word | (WORD_W'(mac_irq) << MAC_BIT);
        cause_set = sync_src & sen_q;
    end

    gpio_irq_regs #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cause_q   (cause_q),
        .pol_q     (pol_q),
        .sen_q     (sen_q),
        .smsk_q    (smsk_q),
        .aen_q     (aen_q),
        .amsk_q    (amsk_q),
        .cause_clr (cause_clr),
        .bus_rdata (bus_rdata)
    );

    gpio_irq_cause u_cause (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (cause_set),
        .clr_vec (cause_clr),
        .cause_q (cause_q)
    );

    gpio_irq_combine u_combine (
        .cause_q   (cause_q),
        .smsk_q    (smsk_q),
        .async_src (async_src),
        .aen_q     (aen_q),
        .amsk_q    (amsk_q),
        .sleep     (sleep),
        .sync_irq  (sync_irq),
        .async_irq (async_irq)
    );

    AST_SYNC_ROSE_FROM_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_irq) |-> (cause_q != '0 && smsk_q != '0)); // R6

endmodule

// File: tb/tb_gpio_irq_router.sv
module tb_gpio_irq_router;
    localparam int NP = 14;
    localparam int GL = 18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NP-1:0] pin_level = '0;
    logic        mac_irq = 1'b0;
    logic [GL-1:0] other_sync_src = '0;
    logic        sleep = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sync_irq, async_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    gpio_irq_router #(.NUM_PINS(NP)) dut (
        .clk(clk), .rst_n(rst_n), .pin_level(pin_level), .mac_irq(mac_irq),
        .other_sync_src(other_sync_src), .sleep(sleep), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sync_irq(sync_irq), .async_irq(async_irq)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check("R1 reg zero", v, 32'h0);
        end
        check("R1 sync low", 32'(sync_irq), 0);
        check("R1 async low", 32'(async_irq), 0);
        rst_n = 1'b1;
        tick();

        // R3 read-back
        wr(3'd1, 32'hA5A5_5A5A); wr(3'd2, 32'h1234_5678);
        wr(3'd4, 32'hFFFF_0001); wr(3'd5, 32'h0F0F_F0F0);
        rd(3'd1, v); check("R3 sen", v, 32'hA5A5_5A5A);
        rd(3'd2, v); check("R3 smsk", v, 32'h1234_5678);
        rd(3'd4, v); check("R3 aen", v, 32'hFFFF_0001);
        rd(3'd5, v); check("R3 amsk", v, 32'h0F0F_F0F0);
        rd(3'd6, v); check("R3 addr6", v, 0);
        rd(3'd7, v); check("R3 addr7", v, 0);
        wr(3'd1, 0); wr(3'd2, 0); wr(3'd4, 0); wr(3'd5, 0);
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, v); check("R2 pol width", v, (32'h1 << NP) - 1);
        wr(3'd0, 0);
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd3, v); check("R3 cause idle", v, 0);

        // R2/R7 polarity sweep on the async path
        wr(3'd4, 32'hFFFF_FFFF); wr(3'd5, 32'hFFFF_FFFF);
        for (int p = 0; p < NP; p++) begin
            for (int pol = 0; pol < 2; pol++) begin
                wr(3'd0, 32'(pol) << p);
                for (int lvl = 0; lvl < 2; lvl++) begin
                    pin_level = NP'(lvl) << p;
                    #1;
                    check($sformatf("R2 R7 pin%0d pol%0d lvl%0d", p, pol, lvl),
                          32'(async_irq), 32'(lvl ^ pol));
                end
            end
        end
        pin_level = '0;
        wr(3'd0, 0); wr(3'd4, 0); wr(3'd5, 0);

        // R4/R5/R6 per-pin latch, hold, clear
        for (int p = 0; p < NP; p++) begin
            logic [31:0] bitv;
            bitv = 32'h1 << (GL + p);
            wr(3'd1, bitv); wr(3'd2, bitv);
            pin_level = NP'(1) << p;
            tick();
            rd(3'd3, v); check($sformatf("R4 set pin%0d", p), v, bitv);
            pin_level = '0;
            tick();
            rd(3'd3, v); check($sformatf("R4 sticky pin%0d", p), v, bitv);
            check($sformatf("R6 sync pin%0d", p), 32'(sync_irq), 1);
            wr(3'd3, bitv);
            rd(3'd3, v); check($sformatf("R5 clear pin%0d", p), v, 0);
            check($sformatf("R6 sync off pin%0d", p), 32'(sync_irq), 0);
        end
        wr(3'd1, 0); wr(3'd2, 0);

        // R5 set wins and partial clear
        wr(3'd1, 32'h3 << GL);
        pin_level = 14'h3;
        tick();
        wr(3'd3, 32'h1 << GL);
        rd(3'd3, v); check("R5 set wins", v, 32'h3 << GL);
        pin_level = '0;
        tick();
        wr(3'd3, 32'h1 << GL);
        rd(3'd3, v); check("R5 partial clear", v, 32'h2 << GL);

        // R6 mask hides latched cause
        check("R6 unmasked low", 32'(sync_irq), 0);
        wr(3'd2, 32'h2 << GL);
        check("R6 masked in", 32'(sync_irq), 1);

        // R8 sleep blanks async, sync unaffected
        mac_irq = 1'b1;
        wr(3'd4, 32'h1); wr(3'd5, 32'h1);
        check("R7 mac async", 32'(async_irq), 1);
        sleep = 1'b1;
        #1;
        check("R8 sleep async", 32'(async_irq), 0);
        check("R8 sleep sync", 32'(sync_irq), 1);
        sleep = 1'b0;
        wr(3'd5, 32'h0);
        check("R7 mac unmasked", 32'(async_irq), 0);
        mac_irq = 1'b0;
        wr(3'd3, 32'hFFFF_FFFF); wr(3'd1, 0); wr(3'd2, 0); wr(3'd4, 0);

        // R9 other sync sources
        other_sync_src = 18'h20;
        tick();
        rd(3'd3, v); check("R9 no enable", v, 0);
        wr(3'd1, 32'h20);
        tick();
        rd(3'd3, v); check("R9 latched", v, 32'h20);
        other_sync_src = '0;
        wr(3'd3, 32'h20); wr(3'd1, 0);
        rd(3'd3, v); check("R9 cleared", v, 0);

        // R10 disable sequence
        wr(3'd1, 32'h1 << (GL + 5)); wr(3'd2, 32'h1 << (GL + 5));
        wr(3'd4, 32'h1 << (GL + 5)); wr(3'd5, 32'h1 << (GL + 5));
        pin_level = 14'h20;
        tick();
        check("R10 before async", 32'(async_irq), 1);
        check("R10 before sync", 32'(sync_irq), 1);
        wr(3'd4, 0); wr(3'd5, 0); wr(3'd1, 0); wr(3'd2, 0);
        wr(3'd3, 32'h1 << (GL + 5));
        tick();
        rd(3'd3, v); check("R10 cause", v, 0);
        check("R10 async", 32'(async_irq), 0);
        check("R10 sync", 32'(sync_irq), 0);
        pin_level = '0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule